// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the device side of a three-wire serial nonvolatile memory. A host drives chip select, a serial clock and serial data in. The block answers on a data-out line that has its own output enable, so it can share a wire with other devices. A register array stands in for the storage cells. An organization input selects between 16-bit words and 8-bit bytes over the same storage.

Every instruction opens with a start bit. An opcode, an address and, for writes, a data field follow. The block counts the bits it expects and acts once the last one has arrived. Reads stream out immediately. Erase and write operations wait for chip select to fall, then run a self-timed program cycle that lasts a fixed number of system clocks. While a cycle is pending, the host can raise chip select to poll ready/busy on data out. Programming is locked out after reset until an enable instruction runs.

All serial inputs are sampled by the system clock `clk_i`. The serial clock must stay high and low for at least two system clocks each.

Top module: `ee3w_slave`

## Requirements
- R1: While chip select is high, serial clock rises with data in low cause no action. The first rise with data in high is taken as the start bit.
- R2: The two opcode bits after the start bit decode as follows: 10 read, 01 write, 11 erase. Opcode 00 is decoded further from the two most significant address bits: 11 enables programming, 00 disables it, 10 erases the whole array, and 01 writes the whole array.
- R3: The frame is start + 2 opcode bits + address. The address is 6 bits when org_i=1 (16-bit words) and 7 bits when org_i=0 (bytes). A write carries 16 or 8 data bits after the address. All fields are MSB first.
- R4: A read drives a 0 on the rise of the last address bit, then the data MSB first, one bit per rise. With chip select held high, the following words come out with no extra 0, and the address wraps at the top of the array.
- R5: After reset, programming is disabled. Write, erase, erase-all and write-all are then dropped with no program cycle and no status. Reads work in both states.
- R6: Erase sets the addressed word or byte to all ones. Erase-all sets every word to all ones. Write-all stores the data into every word; in byte mode the byte is stored in both lanes.
- R7: In byte mode, byte address b selects storage word b>>1. Bit 0 of b picks the lane: 0 selects bits 7:0 and 1 selects bits 15:8. The array resets to all ones.
- R8: A program cycle starts on the fall of chip select after a complete, enabled programming frame. It lasts PROG_CYCLES clocks whatever chip select does.
- R9: After a launch and until the next accepted start bit, raising chip select drives do_oe_o high with do_o=0 while busy and 1 when ready. Chip select low turns do_oe_o off. do_oe_o is low at all other times outside a read.
- R10: A frame cut short by chip select falling is discarded. Clocks and data after the last required bit are ignored.
- R11: A start bit that arrives during a program cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| do_o | output | 1 | Serial data out / ready-busy |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
The assertions check, on every clock, the rules that link the output enable, the program timer and the write-enable latch. Data out is released one clock after chip select drops. A program cycle begins only from a launch, only while programming is enabled, and never overlaps another cycle. Once started, a cycle runs until its commit. Polled status reads 0 while busy. The bench scenarios cover what only sequences of frames can show: the decoding of each opcode, the frame lengths in both organizations, the placement of the dummy bit, sequential reads and address wrap, the byte-lane mapping, discarded short frames, ignored trailing bits, and the array contents after each programming instruction.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  typedef enum logic [2:0] {K_NONE, K_WRITE, K_ERASE, K_ERAL, K_WRAL} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE} st_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_EWEN = 2'b11;
  localparam logic [1:0] SUB_EWDS = 2'b00;
  localparam logic [1:0] SUB_ERAL = 2'b10;
endpackage

// File: rtl/ee3w_sync.sv
module ee3w_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  output logic cs_q_o,
  output logic di_q_o,
  output logic org_q_o,
  output logic sck_rise_o,
  output logic cs_fall_o
);
  logic sck_q, sck_q2, cs_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      sck_q2  <= 1'b0;
      cs_q_o  <= 1'b0;
      cs_q2   <= 1'b0;
      di_q_o  <= 1'b0;
      org_q_o <= 1'b1;
    end else begin
      sck_q   <= sck_i;
      sck_q2  <= sck_q;
      cs_q_o  <= cs_i;
      cs_q2   <= cs_q_o;
      di_q_o  <= di_i;
      org_q_o <= org_i;
    end
  end

  // serial clock is ignored while deselected
  assign sck_rise_o = sck_q & ~sck_q2 & cs_q_o;
  assign cs_fall_o  = cs_q2 & ~cs_q_o;
endmodule

// File: rtl/ee3w_ctrl.sv
module ee3w_ctrl
  import ee3w_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          di_i,
  input  logic          org_i,
  input  logic          sck_rise_i,
  input  logic          cs_fall_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [AW-1:0] rd_idx_o,
  output logic          start_acc_o,
  output logic          launch_o,
  output kind_e         arm_kind_o,
  output logic [AW:0]   arm_addr_o,
  output logic [DW-1:0] arm_data_o,
  output logic          arm_org_o,
  output logic          wen_o,
  output logic          rd_bit_o,
  output logic          st_read_o,
  output logic          st_idle_o
);
  localparam int AWX = AW + 1;
  localparam int HW  = AWX + 2;
  localparam int BW  = DW / 2;
  localparam int CW  = $clog2(DW + HW + 1) + 1;
  localparam int IW  = $clog2(DW);
  localparam logic [CW-1:0] HL16 = CW'(AW + 1);
  localparam logic [CW-1:0] HL8  = CW'(AWX + 1);
  localparam logic [CW-1:0] DL16 = CW'(DW - 1);
  localparam logic [CW-1:0] DL8  = CW'(BW - 1);

  st_e            st;
  logic [HW-1:0]  hdr_sr, nxt_hdr;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  dsr, cur_word;
  logic [AWX-1:0] rd_addr, adr;
  logic [IW-1:0]  bit_idx, wtop;
  logic [1:0]     opc, sub;
  logic           hdr_last, dat_last, armed, do_q;

  always_comb begin
    nxt_hdr = {hdr_sr[HW-2:0], di_i};
    if (org_i) begin
      opc = nxt_hdr[AW+1:AW];
      adr = {1'b0, nxt_hdr[AW-1:0]};
      sub = nxt_hdr[AW-1:AW-2];
    end else begin
      opc = nxt_hdr[AWX+1:AWX];
      adr = nxt_hdr[AWX-1:0];
      sub = nxt_hdr[AWX-1:AWX-2];
    end
    hdr_last = (cnt == (org_i ? HL16 : HL8));
    dat_last = (cnt == (org_i ? DL16 : DL8));
    wtop     = org_i ? IW'(DW - 1) : IW'(BW - 1);
    rd_idx_o = org_i ? rd_addr[AW-1:0] : rd_addr[AWX-1:1];
    if (org_i)           cur_word = rd_word_i;
    else if (rd_addr[0]) cur_word = {{BW{1'b0}}, rd_word_i[DW-1:BW]};
    else                 cur_word = {{BW{1'b0}}, rd_word_i[BW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= S_IDLE;
      hdr_sr     <= '0;
      cnt        <= '0;
      dsr        <= '0;
      rd_addr    <= '0;
      bit_idx    <= '0;
      do_q       <= 1'b0;
      armed      <= 1'b0;
      wen_o      <= 1'b0;
      arm_kind_o <= K_NONE;
      arm_addr_o <= '0;
      arm_org_o  <= 1'b1;
    end else if (!cs_i) begin
      // deselect resets the framing logic, partial frames are lost
      st    <= S_IDLE;
      armed <= 1'b0;
    end else if (sck_rise_i) begin
      unique case (st)
        S_IDLE: begin
          if (di_i && !busy_i) begin
            st     <= S_HDR;
            cnt    <= '0;
            hdr_sr <= '0;
          end
        end
        S_HDR: begin
          hdr_sr <= nxt_hdr;
          cnt    <= cnt + 1'b1;
          if (hdr_last) begin
            cnt        <= '0;
            arm_addr_o <= adr;
            arm_org_o  <= org_i;
            unique case (opc)
              OPC_READ: begin
                st      <= S_READ;
                rd_addr <= adr;
                bit_idx <= wtop;
                do_q    <= 1'b0;
              end
              OPC_WRITE: begin
                st         <= S_DATA;
                arm_kind_o <= K_WRITE;
              end
              OPC_ERASE: begin
                st         <= S_DONE;
                arm_kind_o <= K_ERASE;
                armed      <= 1'b1;
              end
              default: begin
                unique case (sub)
                  SUB_EWEN: begin
                    wen_o <= 1'b1;
                    st    <= S_DONE;
                  end
                  SUB_EWDS: begin
                    wen_o <= 1'b0;
                    st    <= S_DONE;
                  end
                  SUB_ERAL: begin
                    arm_kind_o <= K_ERAL;
                    armed      <= 1'b1;
                    st         <= S_DONE;
                  end
                  default: begin
                    arm_kind_o <= K_WRAL;
                    st         <= S_DATA;
                  end
                endcase
              end
            endcase
          end
        end
        S_DATA: begin
          dsr <= {dsr[DW-2:0], di_i};
          cnt <= cnt + 1'b1;
          if (dat_last) begin
            armed <= 1'b1;
            st    <= S_DONE;
          end
        end
        S_READ: begin
          do_q <= cur_word[bit_idx];
          if (bit_idx == '0) begin
            bit_idx <= wtop;
            if (org_i) rd_addr <= {1'b0, rd_addr[AW-1:0] + AW'(1)};
            else       rd_addr <= rd_addr + AWX'(1);
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign start_acc_o = sck_rise_i & (st == S_IDLE) & di_i & ~busy_i;
  assign launch_o    = cs_fall_i & armed & wen_o & ~busy_i;
  assign arm_data_o  = dsr;
  assign rd_bit_o    = do_q;
  assign st_read_o   = (st == S_READ);
  assign st_idle_o   = (st == S_IDLE);
endmodule

// File: rtl/ee3w_prog.sv
module ee3w_prog
  import ee3w_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          start_acc_i,
  input  kind_e         kind_i,
  input  logic [AW:0]   addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          org_i,
  output logic          busy_o,
  output logic          stat_pend_o,
  output logic          commit_o,
  output kind_e         kind_o,
  output logic [AW:0]   addr_o,
  output logic [DW-1:0] data_o,
  output logic          org_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(PROG_CYCLES - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      stat_pend_o <= 1'b0;
      tmr         <= '0;
      kind_o      <= K_NONE;
      addr_o      <= '0;
      data_o      <= '0;
      org_o       <= 1'b1;
    end else begin
      if (launch_i) begin
        busy_o      <= 1'b1;
        stat_pend_o <= 1'b1;
        tmr         <= '0;
        kind_o      <= kind_i;
        addr_o      <= addr_i;
        data_o      <= data_i;
        org_o       <= org_i;
      end else begin
        if (busy_o) begin
          if (tmr == TLAST) busy_o <= 1'b0;
          else              tmr    <= tmr + 1'b1;
        end
        if (start_acc_i) stat_pend_o <= 1'b0;
      end
    end
  end

  assign commit_o = busy_o & (tmr == TLAST);
endmodule

// File: rtl/ee3w_mem.sv
module ee3w_mem
  import ee3w_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  kind_e         kind_i,
  input  logic [AW:0]   addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          org_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_word_o
);
  localparam int NW = 1 << AW;
  localparam int BW = DW / 2;

  logic [DW-1:0] mem [NW];

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic          hit;
    logic [DW-1:0] nxt;

    always_comb begin
      hit = org_i ? (addr_i[AW-1:0] == AW'(i)) : (addr_i[AW:1] == AW'(i));
      nxt = mem[i];
      unique case (kind_i)
        K_ERASE, K_WRITE: begin
          if (hit) begin
            if (org_i)          nxt = (kind_i == K_ERASE) ? '1 : data_i;
            else if (addr_i[0]) nxt[DW-1:BW] = (kind_i == K_ERASE) ? '1 : data_i[BW-1:0];
            else                nxt[BW-1:0]  = (kind_i == K_ERASE) ? '1 : data_i[BW-1:0];
          end
        end
        K_ERAL:  nxt = '1;
        K_WRAL:  nxt = org_i ? data_i : {data_i[BW-1:0], data_i[BW-1:0]};
        default: ;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mem[i] <= '1;
      else if (commit_i) mem[i] <= nxt;
    end
  end

  assign rd_word_o = mem[rd_idx_i];
endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave
  import ee3w_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_q, di_q, org_q, sck_rise, cs_fall;
  logic              start_acc, prog_go, wr_en, rd_bit, st_read, st_idle;
  logic              prog_busy, stat_pend, mem_commit, arm_org, c_org;
  kind_e             arm_kind, c_kind;
  logic [ADDR_W:0]   arm_addr, c_addr;
  logic [DATA_W-1:0] arm_data, c_data, rd_word;
  logic [ADDR_W-1:0] rd_idx;

  ee3w_sync u_sync (
    .clk_i, .rst_ni, .cs_i, .sck_i, .di_i, .org_i,
    .cs_q_o(cs_q), .di_q_o(di_q), .org_q_o(org_q),
    .sck_rise_o(sck_rise), .cs_fall_o(cs_fall)
  );

  ee3w_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_i(cs_q), .di_i(di_q), .org_i(org_q),
    .sck_rise_i(sck_rise), .cs_fall_i(cs_fall), .busy_i(prog_busy),
    .rd_word_i(rd_word), .rd_idx_o(rd_idx),
    .start_acc_o(start_acc), .launch_o(prog_go),
    .arm_kind_o(arm_kind), .arm_addr_o(arm_addr), .arm_data_o(arm_data),
    .arm_org_o(arm_org), .wen_o(wr_en), .rd_bit_o(rd_bit),
    .st_read_o(st_read), .st_idle_o(st_idle)
  );

  ee3w_prog #(.AW(ADDR_W), .DW(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i, .rst_ni,
    .launch_i(prog_go), .start_acc_i(start_acc),
    .kind_i(arm_kind), .addr_i(arm_addr), .data_i(arm_data), .org_i(arm_org),
    .busy_o(prog_busy), .stat_pend_o(stat_pend), .commit_o(mem_commit),
    .kind_o(c_kind), .addr_o(c_addr), .data_o(c_data), .org_o(c_org)
  );

  ee3w_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .commit_i(mem_commit), .kind_i(c_kind), .addr_i(c_addr),
    .data_i(c_data), .org_i(c_org),
    .rd_idx_i(rd_idx), .rd_word_o(rd_word)
  );

  assign do_oe_o = cs_q & (st_read | (st_idle & stat_pend));
  assign do_o    = st_read ? rd_bit : ~prog_busy;
endmodule

// File: rtl/ee3w_chk.sv
module ee3w_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy_i,
  input logic wen_i,
  input logic launch_i,
  input logic commit_i
);
  // R9
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);
  // R9
  busy_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && busy_i) |-> !do_o);
  // R5
  locked_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> wen_i);
  // R8
  busy_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(launch_i));
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !commit_i) |=> busy_i);
  // R11
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_i);
endmodule

bind ee3w_slave ee3w_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .do_o(do_o), .do_oe_o(do_oe_o),
  .busy_i(prog_busy), .wen_i(wr_en), .launch_i(prog_go), .commit_i(mem_commit)
);

// File: tb/sim_ee3w_slave.sv
`timescale 1ns/1ps
module sim_ee3w_slave;
  localparam int PROG = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
  logic do_w, oe_w;
  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int obs_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ee3w_slave #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .org_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b);
    sck = 1'b0; di = b; tick(4);
    sck = 1'b1; tick(4);
  endtask

  task automatic send(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic sel_on();
    cs = 1'b1; tick(4);
  endtask

  task automatic sel_off();
    sck = 1'b0; di = 1'b0; tick(2);
    cs = 1'b0; tick(4);
  endtask

  function automatic int abits();
    return org ? 6 : 7;
  endfunction

  task automatic header(input int opc, input int adr);
    clk_bit(1'b1);
    send(opc, 2);
    send(adr, abits());
  endtask

  task automatic special(input int sub);
    header(0, org ? (sub << 4) : (sub << 5));
  endtask

  task automatic write_w(input int adr, input int dat);
    sel_on();
    header(1, adr);
    send(dat, org ? 16 : 8);
    sel_off();
    tick(PROG + 16);
  endtask

  task automatic expect_word(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // driver side of a read: frame, dummy check, then hand words to monitor
  task automatic rd(input int adr, input int nw, input int lead);
    int word;
    sel_on();
    send(0, lead);
    clk_bit(1'b1);
    send(2, 2);
    send(adr >> 1, abits() - 1);
    chk(oe_w == 1'b0, "R3 frame not complete before last address bit", int'(oe_w), 0);
    clk_bit(adr[0]);
    chk(oe_w == 1'b1 && do_w == 1'b0, "R4 dummy zero", int'({oe_w, do_w}), 2);
    for (int w = 0; w < nw; w++) begin
      word = 0;
      for (int b = 0; b < (org ? 16 : 8); b++) begin
        clk_bit(1'b0);
        word = (word << 1) | int'(do_w);
      end
      obs_q.push_back(word);
    end
    sel_off();
  endtask

  // monitor: compare produced words with expected ones in order
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        int a, e;
        string t;
        a = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  initial begin
    tick(100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk(oe_w == 1'b0, "R9 reset output disabled", int'(oe_w), 0);

    // R5: locked by default
    sel_on(); header(1, 5); send(16'h1234, 16); sel_off();
    sel_on();
    chk(oe_w == 1'b0, "R5 no status when locked", int'(oe_w), 0);
    sel_off();
    expect_word(16'hFFFF, "R5 write dropped while locked");
    rd(5, 1, 0);

    // R2: enable, then a timed write with status polling
    sel_on(); special(3); sel_off();
    sel_on(); header(1, 5); send(16'hA5C3, 16); sel_off();
    tick(2);
    sel_on();
    chk(oe_w == 1'b1 && do_w == 1'b0, "R8 busy after cs fall", int'({oe_w, do_w}), 2);
    clk_bit(1'b1);
    chk(oe_w == 1'b1 && do_w == 1'b0, "R11 start ignored while busy", int'({oe_w, do_w}), 2);
    sel_off();
    chk(oe_w == 1'b0, "R9 released on cs low", int'(oe_w), 0);
    tick(PROG + 16);
    sel_on();
    chk(oe_w == 1'b1 && do_w == 1'b1, "R9 ready status", int'({oe_w, do_w}), 3);
    sel_off();

    write_w(6, 16'h0F0F);
    expect_word(16'hA5C3, "R4 first word");
    expect_word(16'h0F0F, "R4 sequential word");
    rd(5, 2, 0);
    write_w(63, 16'hBEEF);
    expect_word(16'hBEEF, "R4 top word");
    expect_word(16'hFFFF, "R4 wrap to zero");
    rd(63, 2, 0);

    // R10: short frame dropped, trailing bits ignored
    sel_on(); header(1, 7); send(0, 10); sel_off();
    sel_on();
    chk(oe_w == 1'b0, "R10 short frame no launch", int'(oe_w), 0);
    sel_off();
    expect_word(16'hFFFF, "R10 short frame discarded");
    rd(7, 1, 0);
    sel_on(); header(3, 5); send(5'h1F, 5); sel_off(); tick(PROG + 16);
    expect_word(16'hFFFF, "R6 erase word with trailing bits R10");
    rd(5, 1, 0);

    // R1: idle clocks before start
    expect_word(16'h0F0F, "R1 leading clocks ignored");
    rd(6, 1, 5);

    // R7: byte mode
    org = 1'b0;
    write_w(13, 8'h5A);
    expect_word(8'h0F, "R7 low lane of byte 12");
    rd(12, 1, 0);
    expect_word(8'h0F, "R4 byte sequential first");
    expect_word(8'h5A, "R4 byte sequential second");
    rd(12, 2, 0);
    org = 1'b1;
    tick(4);
    expect_word(16'h5A0F, "R7 byte landed in high lane");
    rd(6, 1, 0);

    // R6 / R2: erase all, write all
    sel_on(); special(2); sel_off(); tick(PROG + 16);
    expect_word(16'hFFFF, "R6 erase all R2");
    rd(6, 1, 0);
    sel_on(); special(1); send(16'h1357, 16); sel_off(); tick(PROG + 16);
    expect_word(16'h1357, "R6 write all top");
    expect_word(16'h1357, "R6 write all bottom");
    rd(63, 2, 0);

    // R5 / R2: disable again
    sel_on(); special(0); sel_off();
    write_w(0, 16'h0000);
    expect_word(16'h1357, "R5 locked after disable R2");
    rd(0, 1, 0);

    tick(8);
    if (exp_q.size() != 0) chk(1'b0, "R4 words missing", obs_q.size(), exp_q.size());
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule